// File: doc/BRIEF.md
# Type 1 Configuration Write Forwarding Decoder

This block sits beside the address-phase logic of a two-sided bus bridge. It classifies each configuration write it sees. Two kinds of write get special handling, and both use the broadcast device/function address (device 31, function 7). One kind is passed upstream unchanged as a Type 1 write. The other is rewritten into a special cycle on the far bus. Every other cycle produces no decision.

Each cycle marked by `req_valid` is decoded from several inputs:
- the address word;
- the command nibble;
- a direction flag;
- the three bus number settings (primary, secondary, subordinate);
- a flag that says the initiator wants more than one data transfer.

The decision is registered and appears one clock later. It consists of two mutually exclusive flags, the outgoing command code and a disconnect request. The disconnect limits a forwarded cycle to a single transfer.

Top module: `cfg_fwd_decoder`

## Requirements
- R1: After reset, and until the first decoded request, `fwd_type1`, `make_special`, `disconnect` and `out_cmd` are all zero.
- R2: Outputs are registered. A request presented on one rising edge is reflected on the next. A cycle with `req_valid` low yields all outputs zero after the next edge.
- R3: A cycle is a candidate only if all of the following hold: `cmd` is 4'b1011 (configuration write), `addr[1:0]` is 2'b01, `addr[15:11]` is 5'b11111 and `addr[10:8]` is 3'b111. A non-candidate raises neither decision.
- R4: Going downstream (`dir_up`=0), a candidate is converted to a special cycle when the bus field `addr[23:16]` equals `sec_bus` and the register field `addr[7:2]` is zero.
- R5: Going upstream (`dir_up`=1), a candidate is converted when `addr[23:16]` equals `pri_bus` and `addr[7:2]` is zero.
- R6: Going upstream, a candidate that is not converted is forwarded as a Type 1 write when `addr[23:16]` is below `sec_bus` or above `sub_bus`. The range from `sec_bus` to `sub_bus` is inclusive, so a bus number inside it, including either bound, is never forwarded. A downstream cycle is never forwarded.
- R7: `fwd_type1` and `make_special` are never both high. When both rules match, conversion wins.
- R8: `out_cmd` is 4'b0001 (special cycle) when converting. Otherwise it is the incoming command unchanged for a valid request.
- R9: `disconnect` is high exactly when a decision flag is high and `multi_xfer` was set for that request.
- R10: An incoming special cycle (`cmd` 4'b0001) is ignored: neither decision is raised.
- R11: A non-zero register field blocks conversion but not upstream forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Address phase of a cycle to decode |
| addr | input | 32 | Address word of the cycle |
| cmd | input | 4 | Bus command nibble |
| dir_up | input | 1 | 1 = cycle travels upstream, 0 = downstream |
| pri_bus | input | 8 | Primary bus number setting |
| sec_bus | input | 8 | Secondary bus number setting |
| sub_bus | input | 8 | Subordinate bus number setting |
| multi_xfer | input | 1 | Initiator requests more than one data transfer |
| fwd_type1 | output | 1 | Forward upstream as a Type 1 write |
| make_special | output | 1 | Convert to a special cycle on the target bus |
| out_cmd | output | 4 | Command to drive on the target bus |
| disconnect | output | 1 | Disconnect during the first data phase |

## Verification
The bench aims at the edges of the bus range and at the matching rules.

- **Range bounds.** It places upstream bus numbers exactly on `sec_bus` and on `sub_bus`, and just outside each. A comparator with the wrong inclusivity forwards a cycle whose bus lies behind the bridge, or drops a legal one.
- **Both rules matching.** It presents an upstream cycle addressed to the primary bus, which lies outside the range. A decoder without the priority would raise both flags.
- **Direction.** It uses the secondary bus number in the wrong direction. A decoder that ignores direction would convert the cycle.
- **Single field wrong.** It sends broadcast-address cycles with one field altered: type bits, device, function, register, or the command (read, or an incoming special cycle). A decoder that leaves out any one test would fire a decision on one of these cycles.

// File: rtl/cfg_fwd_pkg.sv
package cfg_fwd_pkg;
    localparam int CMD_W = 4;
    typedef logic [CMD_W-1:0] cmd_t;

    localparam cmd_t CMD_CFG_WR  = 4'b1011;
    localparam cmd_t CMD_SPECIAL = 4'b0001;

    typedef struct packed {
        logic fwd;
        logic spc;
        logic disc;
        cmd_t cmd;
    } dec_s;
endpackage

// File: rtl/cfg_fwd_field_match.sv
module cfg_fwd_field_match
    import cfg_fwd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  cmd_t              cmd,
    output logic              is_cand,
    output logic              reg_zero,
    output logic [BUS_W-1:0]  bus_num
);
    localparam int TYPE_W  = 2;
    localparam int REG_LSB = TYPE_W;
    localparam int REG_W   = 6;
    localparam int FN_LSB  = REG_LSB + REG_W;
    localparam int FN_W    = 3;
    localparam int DEV_LSB = FN_LSB + FN_W;
    localparam int DEV_W   = 5;
    localparam int BUS_LSB = DEV_LSB + DEV_W;

    logic type_ok, dev_ok, fn_ok, cmd_ok;

    always_comb begin
        type_ok  = addr[TYPE_W-1:0] == 2'b01;
        dev_ok   = &addr[DEV_LSB +: DEV_W];
        fn_ok    = &addr[FN_LSB +: FN_W];
        cmd_ok   = cmd == CMD_CFG_WR;
        is_cand  = type_ok && dev_ok && fn_ok && cmd_ok;
        reg_zero = addr[REG_LSB +: REG_W] == '0;
        bus_num  = addr[BUS_LSB +: BUS_W];
    end
endmodule

// File: rtl/cfg_fwd_bus_cmp.sv
module cfg_fwd_bus_cmp #(
    parameter int BUS_W = 8
) (
    input  logic [BUS_W-1:0] bus_num,
    input  logic [BUS_W-1:0] pri_bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    input  logic             dir_up,
    output logic             own_hit,
    output logic             outside
);
    logic [BUS_W-1:0] own_bus;

    always_comb begin
        own_bus = dir_up ? pri_bus : sec_bus;
        own_hit = bus_num == own_bus;
        outside = (bus_num < sec_bus) || (bus_num > sub_bus);
    end
endmodule

// File: rtl/cfg_fwd_decoder.sv
module cfg_fwd_decoder
    import cfg_fwd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    input  logic              dir_up,
    input  logic [BUS_W-1:0]  pri_bus,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    input  logic              multi_xfer,
    output logic              fwd_type1,
    output logic              make_special,
    output logic [3:0]        out_cmd,
    output logic              disconnect
);
    logic             is_cand, reg_zero, own_hit, outside;
    logic [BUS_W-1:0] bus_num;
    dec_s             dec_d, dec_q;

    cfg_fwd_field_match #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_field (
        .addr     (addr),
        .cmd      (cmd),
        .is_cand  (is_cand),
        .reg_zero (reg_zero),
        .bus_num  (bus_num)
    );

    cfg_fwd_bus_cmp #(.BUS_W(BUS_W)) u_cmp (
        .bus_num (bus_num),
        .pri_bus (pri_bus),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .dir_up  (dir_up),
        .own_hit (own_hit),
        .outside (outside)
    );

    // Conversion takes priority over upstream forwarding (R7).
    always_comb begin
        dec_d = '0;
        if (req_valid) begin
            dec_d.spc  = is_cand && reg_zero && own_hit;
            dec_d.fwd  = is_cand && dir_up && outside && !dec_d.spc;
            dec_d.disc = (dec_d.spc || dec_d.fwd) && multi_xfer;
            dec_d.cmd  = dec_d.spc ? CMD_SPECIAL : cmd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign fwd_type1    = dec_q.fwd;
    assign make_special = dec_q.spc;
    assign disconnect   = dec_q.disc;
    assign out_cmd      = dec_q.cmd;

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_type1 && make_special));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !fwd_type1 && !make_special && !disconnect);

    p_disc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !multi_xfer) |=> !disconnect);

    p_spcmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        make_special |-> out_cmd == CMD_SPECIAL);

    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cmd != CMD_CFG_WR) |=> !fwd_type1 && !make_special);

    p_dnfwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dir_up) |=> !fwd_type1);
endmodule

// File: tb/cfg_fwd_decoder_bench.sv
module cfg_fwd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  cmd = '0;
    logic        dir_up = 1'b0;
    logic [7:0]  pri_bus = 8'd2;
    logic [7:0]  sec_bus = 8'd5;
    logic [7:0]  sub_bus = 8'd9;
    logic        multi_xfer = 1'b0;
    logic        fwd_type1, make_special, disconnect;
    logic [3:0]  out_cmd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfg_fwd_decoder u_cfg_fwd_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .addr(addr),
        .cmd(cmd), .dir_up(dir_up), .pri_bus(pri_bus), .sec_bus(sec_bus),
        .sub_bus(sub_bus), .multi_xfer(multi_xfer), .fwd_type1(fwd_type1),
        .make_special(make_special), .out_cmd(out_cmd), .disconnect(disconnect)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        up;
        logic        multi;
        logic [3:0]  c;
        logic [31:0] a;
        logic        e_fwd;
        logic        e_spc;
        logic        e_disc;
        logic [3:0]  e_cmd;
    } vec_t;

    // pri=2 sec=5 sub=9; broadcast device/function -> addr[15:8]=FF, addr[1:0]=01
    localparam vec_t VEC [0:16] = '{
        '{4'd4,  1'b0, 1'b0, 4'hB, 32'h0005FF01, 1'b0, 1'b1, 1'b0, 4'h1}, // R4
        '{4'd9,  1'b0, 1'b1, 4'hB, 32'h0005FF01, 1'b0, 1'b1, 1'b1, 4'h1}, // R9
        '{4'd5,  1'b1, 1'b0, 4'hB, 32'h0002FF01, 1'b0, 1'b1, 1'b0, 4'h1}, // R5
        '{4'd6,  1'b1, 1'b0, 4'hB, 32'h0020FF01, 1'b1, 1'b0, 1'b0, 4'hB}, // R6
        '{4'd6,  1'b1, 1'b0, 4'hB, 32'h0005FF01, 1'b0, 1'b0, 1'b0, 4'hB}, // R6 lower bound
        '{4'd6,  1'b1, 1'b0, 4'hB, 32'h0009FF01, 1'b0, 1'b0, 1'b0, 4'hB}, // R6 upper bound
        '{4'd6,  1'b1, 1'b0, 4'hB, 32'h0004FF01, 1'b1, 1'b0, 1'b0, 4'hB}, // R6 below
        '{4'd9,  1'b1, 1'b1, 4'hB, 32'h000AFF01, 1'b1, 1'b0, 1'b1, 4'hB}, // R9 above
        '{4'd6,  1'b0, 1'b0, 4'hB, 32'h0020FF01, 1'b0, 1'b0, 1'b0, 4'hB}, // R6 downstream
        '{4'd11, 1'b1, 1'b0, 4'hB, 32'h0020FF05, 1'b1, 1'b0, 1'b0, 4'hB}, // R11
        '{4'd11, 1'b0, 1'b0, 4'hB, 32'h0005FF05, 1'b0, 1'b0, 1'b0, 4'hB}, // R11
        '{4'd10, 1'b0, 1'b0, 4'h1, 32'h0005FF01, 1'b0, 1'b0, 1'b0, 4'h1}, // R10
        '{4'd3,  1'b0, 1'b0, 4'hB, 32'h0005FF00, 1'b0, 1'b0, 1'b0, 4'hB}, // R3 type
        '{4'd3,  1'b0, 1'b0, 4'hB, 32'h0005F701, 1'b0, 1'b0, 1'b0, 4'hB}, // R3 device
        '{4'd3,  1'b0, 1'b0, 4'hB, 32'h0005FE01, 1'b0, 1'b0, 1'b0, 4'hB}, // R3 function
        '{4'd8,  1'b0, 1'b0, 4'hA, 32'h0005FF01, 1'b0, 1'b0, 1'b0, 4'hA}, // R8 read
        '{4'd7,  1'b1, 1'b1, 4'hB, 32'h0002FF01, 1'b0, 1'b1, 1'b1, 4'h1}  // R7
    };

    task automatic chk(input bit ok, input int rq, input int act, input int exp_v,
                       input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp_v);
        end
    endtask

    task automatic chk_all(input int rq, input logic ef, input logic es,
                           input logic ed, input logic [3:0] ec);
        chk(fwd_type1 == ef, rq, fwd_type1, ef, "fwd_type1");
        chk(make_special == es, rq, make_special, es, "make_special");
        chk(disconnect == ed, rq, disconnect, ed, "disconnect");
        chk(out_cmd == ec, rq, out_cmd, ec, "out_cmd");
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all(1, 1'b0, 1'b0, 1'b0, 4'h0); // R1 in reset
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(1, 1'b0, 1'b0, 1'b0, 4'h0); // R1 after release, no request

        for (int i = 0; i < 17; i++) begin
            req_valid  = 1'b1;
            dir_up     = VEC[i].up;
            multi_xfer = VEC[i].multi;
            cmd        = VEC[i].c;
            addr       = VEC[i].a;
            @(negedge clk);
            chk_all(int'(VEC[i].req), VEC[i].e_fwd, VEC[i].e_spc, VEC[i].e_disc, VEC[i].e_cmd);
        end

        // R2: matching cycle with valid low decodes to zero
        req_valid = 1'b0; dir_up = 1'b0; multi_xfer = 1'b1;
        cmd = 4'hB; addr = 32'h0005FF01;
        @(negedge clk);
        chk_all(2, 1'b0, 1'b0, 1'b0, 4'h0);

        // R2: one-cycle latency, output not yet updated before the edge
        req_valid = 1'b1; multi_xfer = 1'b0;
        #1;
        chk(make_special == 1'b0, 2, make_special, 0, "before edge");
        @(negedge clk);
        chk(make_special == 1'b1, 2, make_special, 1, "after edge");

        // R4 with changed register setting: downstream bus 7 = sec
        sec_bus = 8'd7; addr = 32'h0007FF01;
        @(negedge clk);
        chk_all(4, 1'b0, 1'b1, 1'b0, 4'h1);

        req_valid = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule